// File: doc/BRIEF.md
# UART Transmit Holding Status Controller

This block manages the one-character holding stage in front of a UART transmit serializer. The CPU writes characters into it. The block decides when a held character passes to the shift register, and it raises a one-cycle load strobe that carries the character. It also keeps two status flags for software. The ready flag means the holding stage can take a character. The empty flag means the transmit path has drained completely after the final stop bit.

The serializer reports the end of each character with a shift-done pulse. From the load strobe and that pulse, the block tracks whether the shifter is busy. The transmit enable controls both flags. While the enable is low, nothing is accepted and nothing is loaded. Any character left in the holding stage is dropped, so it is never sent once the transmitter is enabled again. The reset input is asynchronous and active low. Inside the block, its release is synchronised to the clock.

Top module: `uart_txhold_ctl`

## Requirements
- R1: While reset is asserted, and after it is released with the enable low, `load_pulse`, `tx_ready` and `tx_empty` are all 0. Asserting reset forces them to 0 at once.
- R2: While enabled, `tx_ready` is 1 exactly when the holding stage is free. An accepted write clears it at the next clock edge. It sets again at the same edge that registers the load strobe for that character.
- R3: `tx_ready` goes to 1 at the first clock edge with the enable high and the holding stage free. A clock edge with the enable low forces both `tx_ready` and `tx_empty` to 0.
- R4: A load fires when the enable is high, a character is held and the shifter is idle. One cycle later, `load_pulse` is high for a single cycle, and `load_data` carries the held character.
- R5: `tx_empty` sets at the edge after a shift-done pulse if the shifter was busy, the enable is high, no character is held and no write arrives in that cycle.
- R6: An accepted write clears `tx_empty` at the next clock edge.
- R7: A write made while the enable is low never produces a load. A character still held when the enable drops is discarded and is never loaded after re-enable.
- R8: A shift-done pulse while the shifter is idle has no effect on either flag.
- R9: A write in the same cycle that a load fires is kept as the next held character. It is loaded after the following shift-done pulse.
- R10: Between a load and the shift-done pulse that ends it, no further load is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe for the holding stage |
| wr_data | input | DATA_W | Character written by the CPU |
| tx_enable | input | 1 | Transmitter enable level |
| shift_done | input | 1 | Serializer pulse after the final stop bit |
| load_pulse | output | 1 | One-cycle strobe: shift register takes `load_data` |
| load_data | output | DATA_W | Character handed to the serializer |
| tx_ready | output | 1 | Holding stage free and transmitter enabled |
| tx_empty | output | 1 | Transmit path fully drained |

## Verification
Suppose the held-character valid bit is wrong. A stuck-set bit shows at the ports as a missing `tx_ready` and as a spurious `load_pulse` in the very next cycle. A stuck-clear bit shows as a character that never appears on `load_data`. A busy tracker that clears early would issue a second load before shift-done. One that never clears would block every later load and keep `tx_empty` low. Both show up within one character time. The vector table pins every flag edge to its exact cycle. A shifter model then checks the order of the characters sent and that no character written while disabled ever leaves the block.

// File: rtl/txh_pkg.sv
package txh_pkg;
  parameter int TXH_DW          = 8;
  parameter int TXH_SYNC_STAGES = 2;

  typedef struct packed {
    logic ready;
    logic empty;
  } txh_flags_t;
endpackage

// File: rtl/txh_rst_sync.sv
module txh_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[LAST-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[LAST];
endmodule

// File: rtl/txh_hold_reg.sv
module txh_hold_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          tx_enable,
  input  logic          shifter_busy,
  output logic          hold_valid_nxt,
  output logic          load_fire,
  output logic          load_pulse,
  output logic [DW-1:0] load_data
);
  logic          hold_valid_q;
  logic [DW-1:0] hold_data_q;
  logic          wr_accept;
  logic          load_pulse_d;

  // next-state
  always_comb begin
    wr_accept    = wr_en & tx_enable;
    load_fire    = tx_enable & hold_valid_q & ~shifter_busy;
    load_pulse_d = load_fire;
    if (wr_accept)       hold_valid_nxt = 1'b1;
    else if (!tx_enable) hold_valid_nxt = 1'b0;
    else                 hold_valid_nxt = hold_valid_q & ~load_fire;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid_q <= 1'b0;
      load_pulse   <= 1'b0;
    end else begin
      hold_valid_q <= hold_valid_nxt;
      load_pulse   <= load_pulse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data_q <= '0;
    end else if (wr_accept) begin
      hold_data_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_data <= '0;
    end else if (load_fire) begin
      load_data <= hold_data_q;
    end
  end

  p_load_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> !load_pulse);
  p_no_load_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |-> !load_fire);
  p_load_after_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> load_pulse);
endmodule

// File: rtl/txh_busy_track.sv
module txh_busy_track (
  input  logic clk,
  input  logic rst_n,
  input  logic load_fire,
  input  logic shift_done,
  output logic shifter_busy,
  output logic shift_end
);
  logic busy_d;

  always_comb begin
    if (load_fire)       busy_d = 1'b1;
    else if (shift_done) busy_d = 1'b0;
    else                 busy_d = shifter_busy;
    shift_end = shift_done & shifter_busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shifter_busy <= 1'b0;
    else        shifter_busy <= busy_d;
  end

  p_no_load_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    shifter_busy |-> !load_fire);
endmodule

// File: rtl/txh_flags.sv
module txh_flags
  import txh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_enable,
  input  logic       wr_en,
  input  logic       hold_valid_nxt,
  input  logic       shift_end,
  output txh_flags_t flags
);
  txh_flags_t flags_d;
  logic       wr_accept;

  always_comb begin
    wr_accept     = wr_en & tx_enable;
    flags_d.ready = tx_enable & ~hold_valid_nxt;
    if (!tx_enable || wr_accept)          flags_d.empty = 1'b0;
    else if (shift_end && !hold_valid_nxt) flags_d.empty = 1'b1;
    else                                   flags_d.empty = flags.empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end

  p_disable_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |=> (!flags.ready && !flags.empty));
  p_write_clears_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tx_enable) |=> !flags.empty);
  p_empty_implies_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flags.empty |-> flags.ready);
endmodule

// File: rtl/uart_txhold_ctl.sv
module uart_txhold_ctl
  import txh_pkg::*;
#(
  parameter int DATA_W      = TXH_DW,
  parameter int SYNC_STAGES = TXH_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_enable,
  input  logic              shift_done,
  output logic              load_pulse,
  output logic [DATA_W-1:0] load_data,
  output logic              tx_ready,
  output logic              tx_empty
);
  logic       rst_n_int;
  logic       hold_valid_nxt;
  logic       load_fire;
  logic       shifter_busy;
  logic       shift_end;
  txh_flags_t flags;

  txh_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  txh_hold_reg #(.DW(DATA_W)) u_hold (
    .clk            (clk),
    .rst_n          (rst_n_int),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .tx_enable      (tx_enable),
    .shifter_busy   (shifter_busy),
    .hold_valid_nxt (hold_valid_nxt),
    .load_fire      (load_fire),
    .load_pulse     (load_pulse),
    .load_data      (load_data)
  );

  txh_busy_track u_busy (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .load_fire    (load_fire),
    .shift_done   (shift_done),
    .shifter_busy (shifter_busy),
    .shift_end    (shift_end)
  );

  txh_flags u_flags (
    .clk            (clk),
    .rst_n          (rst_n_int),
    .tx_enable      (tx_enable),
    .wr_en          (wr_en),
    .hold_valid_nxt (hold_valid_nxt),
    .shift_end      (shift_end),
    .flags          (flags)
  );

  assign tx_ready = flags.ready;
  assign tx_empty = flags.empty;

  p_ready_load_r2: assert property (@(posedge clk) disable iff (!rst_n_int)
    load_pulse |-> tx_ready || $past(wr_en));
endmodule

// File: tb/uart_txhold_ctl_tb.sv
module uart_txhold_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       tx_enable = 1'b0;
  logic       v_done = 1'b0;
  logic       m_done = 1'b0;
  logic       use_model = 1'b0;
  logic       shift_done;
  logic       load_pulse;
  logic [7:0] load_data;
  logic       tx_ready;
  logic       tx_empty;

  int n_chk = 0;
  int n_bad = 0;
  int m_cnt = 0;
  int n_sent = 0;
  logic [7:0] sent [16];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign shift_done = use_model ? m_done : v_done;

  uart_txhold_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tx_enable(tx_enable), .shift_done(shift_done), .load_pulse(load_pulse),
    .load_data(load_data), .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  // serializer model: four cycles per character
  always @(negedge clk) begin
    m_done = 1'b0;
    if (use_model) begin
      if (m_cnt > 0) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) m_done = 1'b1;
      end
      if (load_pulse) begin
        if (n_sent < 16) sent[n_sent] = load_data;
        n_sent = n_sent + 1;
        m_cnt  = 4;
      end
    end
  end

  // {wr, data[7:0], en, done, exp_ld, exp_rdy, exp_emp, exp_ldata[7:0]}
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
    {1'b1, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'hA5},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00},
    {1'b1, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b1, 8'h5A, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h3C},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h5A},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b1, 8'h77, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00}
  };

  function automatic string row_req(int i);
    case (i)
      0:           return "R1";
      1, 14:       return "R3";
      2, 6:        return "R2/R6";
      3, 10:       return "R4";
      4, 8:        return "R10";
      5:           return "R5";
      7:           return "R9";
      9:           return "R5/R9";
      11:          return "R3";
      12, 13, 15:  return "R7";
      default:     return "R8";
    endcase
  endfunction

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_char(logic [7:0] c);
    int guard = 0;
    while (!tx_ready && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    wr_en = 1'b1; wr_data = c;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int loads0;
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1", "ready in reset", {7'd0, tx_ready}, 8'd0);
    check("R1", "empty in reset", {7'd0, tx_empty}, 8'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "load after release", {7'd0, load_pulse}, 8'd0);

    for (int i = 0; i < NV; i++) begin
      wr_en     = VEC[i][21];
      wr_data   = VEC[i][20:13];
      tx_enable = VEC[i][12];
      v_done    = VEC[i][11];
      @(negedge clk);
      check(row_req(i), $sformatf("row %0d load", i), {7'd0, load_pulse}, {7'd0, VEC[i][10]});
      check(row_req(i), $sformatf("row %0d ready", i), {7'd0, tx_ready}, {7'd0, VEC[i][9]});
      check(row_req(i), $sformatf("row %0d empty", i), {7'd0, tx_empty}, {7'd0, VEC[i][8]});
      if (VEC[i][10]) check(row_req(i), $sformatf("row %0d data", i), load_data, VEC[i][7:0]);
    end
    wr_en = 1'b0; v_done = 1'b0;

    // R4/R5/R9: stream through the serializer model
    use_model = 1'b1;
    tx_enable = 1'b1;
    send_char(8'h11); send_char(8'h22); send_char(8'h33); send_char(8'h44);
    for (int k = 0; k < 60 && !tx_empty; k++) @(negedge clk);
    check("R5", "empty after stream", {7'd0, tx_empty}, 8'd1);
    check("R4", "chars sent", n_sent[7:0], 8'd4);
    for (int k = 0; k < 4; k++)
      check("R4", $sformatf("order %0d", k), sent[k], 8'h11 * (k + 1));

    // R7: character held when the enable drops is discarded
    loads0 = n_sent;
    send_char(8'h55);          // goes straight to the shifter
    send_char(8'h66);          // held while the shifter is busy
    tx_enable = 1'b0;
    repeat (8) @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h99;
    @(negedge clk);
    wr_en = 1'b0;
    tx_enable = 1'b1;
    repeat (12) @(negedge clk);
    check("R7", "loads after re-enable", n_sent[7:0], loads0[7:0] + 8'd1);
    check("R7", "ready after re-enable", {7'd0, tx_ready}, 8'd1);
    check("R7", "last sent", sent[n_sent-1], 8'h55);

    // R1: asynchronous reset forces outputs low
    send_char(8'h0F);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "ready async reset", {7'd0, tx_ready}, 8'd0);
    check("R1", "load async reset", {7'd0, load_pulse}, 8'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule